// File: doc/BRIEF.md
# SPI EEPROM Word Read Engine

This block lets a host fetch one 16-bit word from a serial EEPROM on a four-wire SPI bus without toggling any pins itself. The host writes a single 32-bit command register: a start bit plus a word address. The engine then runs the whole read transaction on its own. It lowers chip select, sends the read opcode and a 16-bit byte address, clocks in two data bytes and raises chip select again. It then puts the assembled word into the upper half of the same register and sets a done flag there.

Software starts a read and polls the register until the done flag reads 1, then takes the data from bits 31:16. The SPI clock comes from the system clock through a parameterised divider. The bus runs in mode 0: the clock idles low, the EEPROM's output is captured as the clock rises, and the engine changes its own output only while the clock is low.

Top module: `eerd_engine`

## Requirements
- R1: The command register sits at host byte offset 0x14. Any other offset reads as zero, and writes to other offsets have no effect on the register or the SPI pins.
- R2: A write to 0x14 with bit 0 set, made while the engine is idle, starts a read. It latches the 14-bit word address from bits 15:2 and clears the done flag (bit 1). From the next cycle until the transfer ends, bit 0 reads back 1 (busy).
- R3: A write to 0x14 is ignored if bit 0 is clear or if a transfer is in progress. Address, data and done flag keep their values, and a running transfer completes for its original address.
- R4: Each read is one chip-select-low frame of exactly 40 SCK pulses. The frame carries opcode 0x03, then the 16-bit byte address (twice the word address), both MSB first, then 16 data bits from the EEPROM.
- R5: The bus is mode 0. SCK is low whenever chip select is high, SCK rises only while chip select is low, and MOSI never changes while SCK is high.
- R6: The SCK period is 2×CLK_HALF system clock cycles.
- R7: The first byte received (the lower byte address) lands in bits 23:16. The second byte lands in bits 31:24.
- R8: At the end of the frame, chip select is high, the done flag reads 1 and bits 31:16 hold the new word, all from the same cycle.
- R9: After reset the register reads 0x00000000, chip select is high, and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte offset for writes and reads |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents at host_addr (zero off-map) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The assertions assume that host_wr lasts one cycle with a stable address and data. They also assume that spi_miso changes only on falling SCK, which is how an EEPROM in mode 0 behaves. The bench drives every host access at the falling system clock edge for exactly one cycle. Its EEPROM model updates MISO only on SCK falling edges and only during the data phase. Random word addresses are drawn across the whole 14-bit range. Starts made during a transfer and writes with bit 0 clear are placed so that they could change state if they were not ignored.

// File: rtl/eerd_pkg.sv
`timescale 1ns/1ps
package eerd_pkg;
    localparam int          REG_OFFSET = 'h14;
    localparam int          WORD_AW    = 14;
    localparam int          BYTE_AW    = 16;
    localparam int          FRAME_BITS = 8 + BYTE_AW + 16;
    localparam logic [7:0]  OPC_READ   = 8'h03;

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL} ser_state_e;

    // Host view of the command register, MSB first
    typedef struct packed {
        logic [15:0]        data;
        logic [WORD_AW-1:0] waddr;
        logic               done;
        logic               busy;
    } cmd_reg_t;

    function automatic logic [BYTE_AW-1:0] to_byte_addr(input logic [WORD_AW-1:0] w);
        return {{(BYTE_AW-WORD_AW-1){1'b0}}, w, 1'b0};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [BYTE_AW-1:0] b);
        return {OPC_READ, b, 16'h0000};
    endfunction

    // First byte shifted in is the lower address, so it becomes the low byte
    function automatic logic [15:0] assemble_word(input logic [15:0] rx);
        return {rx[7:0], rx[15:8]};
    endfunction
endpackage

// File: rtl/eerd_tick.sv
`timescale 1ns/1ps
module eerd_tick #(
    parameter int CLK_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/eerd_shift.sv
`timescale 1ns/1ps
module eerd_shift
    import eerd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BYTE_AW-1:0] load_baddr,
    input  logic               advance,
    input  logic               capture,
    input  logic               miso,
    output logic               mosi,
    output logic [15:0]        word
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [15:0]           rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)          tx_q <= build_frame(load_baddr);
            else if (advance)  tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            if (capture)       rx_q <= {rx_q[14:0], miso};
        end
    end

    assign mosi = tx_q[FRAME_BITS-1];
    assign word = assemble_word(rx_q);
endmodule

// File: rtl/eerd_ctrl.sv
`timescale 1ns/1ps
module eerd_ctrl
    import eerd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic tick,
    output logic run,
    output logic advance,
    output logic capture,
    output logic finish,
    output logic sck,
    output logic cs_n
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    ser_state_e      state;
    logic [BW-1:0]   bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    state   <= ST_LOW;
                    bit_cnt <= '0;
                    cs_n    <= 1'b0;
                    sck     <= 1'b0;
                end
                ST_LOW: if (tick) begin
                    sck   <= 1'b1;
                    state <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sck <= 1'b0;
                    if (bit_cnt == LAST_BIT) state <= ST_TAIL;
                    else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= ST_LOW;
                    end
                end
                ST_TAIL: if (tick) begin
                    cs_n  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run     = (state != ST_IDLE);
    assign capture = (state == ST_LOW)  && tick;
    assign advance = (state == ST_HIGH) && tick && (bit_cnt != LAST_BIT);
    assign finish  = (state == ST_TAIL) && tick;

    assert_sck_low_when_deselected_R5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);
    assert_sck_rise_selected_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> !cs_n);
endmodule

// File: rtl/eerd_engine.sv
`timescale 1ns/1ps
module eerd_engine
    import eerd_pkg::*;
#(
    parameter int CLK_HALF = 4,
    parameter int HOST_AW  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam logic [HOST_AW-1:0] OFF = HOST_AW'(REG_OFFSET);

    logic               sel, busy, go, tick, advance, capture, finish;
    logic [15:0]        word;
    logic [WORD_AW-1:0] waddr_q;
    logic [15:0]        data_q;
    logic               done_q;
    cmd_reg_t           view;
    logic               unused_wbits;

    assign unused_wbits = ^{host_wdata[31:16], host_wdata[1]};
    assign sel = (host_addr == OFF);
    assign go  = host_wr && sel && host_wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr_q <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else if (go) begin
            waddr_q <= host_wdata[WORD_AW+1:2];
            done_q  <= 1'b0;
        end else if (finish) begin
            data_q  <= word;
            done_q  <= 1'b1;
        end
    end

    eerd_tick #(.CLK_HALF(CLK_HALF)) i_tick (
        .clk(clk), .rst(rst), .run(busy), .tick(tick)
    );

    eerd_ctrl i_ctrl (
        .clk(clk), .rst(rst), .go(go), .tick(tick), .run(busy),
        .advance(advance), .capture(capture), .finish(finish),
        .sck(spi_sck), .cs_n(spi_cs_n)
    );

    eerd_shift i_shift (
        .clk(clk), .rst(rst), .load(go),
        .load_baddr(to_byte_addr(host_wdata[WORD_AW+1:2])),
        .advance(advance), .capture(capture), .miso(spi_miso),
        .mosi(spi_mosi), .word(word)
    );

    assign view.data  = data_q;
    assign view.waddr = waddr_q;
    assign view.done  = done_q;
    assign view.busy  = busy;
    assign host_rdata = sel ? view : 32'h0;

    assert_mosi_steady_high_sck_R5: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr) |=> $stable(waddr_q));
    assert_done_clears_only_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> $past(host_wr && sel && host_wdata[0]));
    assert_done_with_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (spi_cs_n && !spi_sck));
endmodule

// File: tb/test_eerd_engine.sv
`timescale 1ns/1ps
module test_eerd_engine;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int tests = 0, fails = 0;
    int cyc = 0;

    eerd_engine #(.CLK_HALF(HALF), .HOST_AW(8)) i_eerd_engine (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    // EEPROM contents model
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'h5b) ^ 8'ha5;
    endfunction
    function automatic logic [15:0] exp_word(input logic [13:0] w);
        logic [15:0] b = {1'b0, w, 1'b0};
        return {mem_byte(b + 16'd1), mem_byte(b)};
    endfunction

    // SPI slave model
    int          bitn = 0, rises = 0;
    logic [23:0] shin = '0;
    logic [15:0] stream;
    always @(negedge spi_cs_n) begin
        bitn = 0; rises = 0; shin = '0;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (bitn < 24) shin = {shin[22:0], spi_mosi};
        bitn++; rises++;
    end
    always @(negedge spi_sck) if (!spi_cs_n && bitn >= 24 && bitn < 40) begin
        stream   = {mem_byte(shin[15:0]), mem_byte(shin[15:0] + 16'd1)};
        spi_miso = stream[15 - (bitn - 24)];
    end

    // SCK period monitor
    logic sck_d = 1'b0;
    int   last_rise = 0, per_min = 1000, per_max = 0, nr = 0;
    always @(negedge clk) begin
        cyc++;
        if (spi_sck && !sck_d) begin
            if (nr > 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            nr++; last_rise = cyc;
        end
        sck_d = spi_sck;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_done(output logic [31:0] v);
        for (int i = 0; i < 4000; i++) begin
            rd(8'h14, v);
            if (v[1]) return;
        end
    endtask

    task automatic do_read(input logic [13:0] w);
        logic [31:0] v;
        per_min = 1000; per_max = 0; nr = 0;
        wr(8'h14, {16'h0, w, 2'b01});
        rd(8'h14, v);
        check("R2 busy/done after start", {30'h0, v[1:0]}, 32'h1);
        check("R2 address latched", {18'h0, v[15:2]}, {18'h0, w});
        wait_done(v);
        check("R8 done set", {31'h0, v[1]}, 32'h1);
        check("R7 word value", {16'h0, v[31:16]}, {16'h0, exp_word(w)});
        check("R4 opcode", {24'h0, shin[23:16]}, 32'h03);
        check("R4 byte address", {16'h0, shin[15:0]}, {17'h0, w, 1'b0});
        check("R4 sck pulses", rises, 40);
        check("R5 idle pins", {30'h0, spi_cs_n, spi_sck}, 32'h2);
        check("R6 sck period min", per_min, 2 * HALF);
        check("R6 sck period max", per_max, 2 * HALF);
    endtask

    initial begin
        logic [31:0] v, keep;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(8'h14, v);
        check("R9 register after reset", v, 32'h0);
        check("R9 pins after reset", {29'h0, spi_cs_n, spi_sck, spi_mosi}, 32'h4);

        // R1 other offsets
        wr(8'h10, 32'hffff_ffff);
        repeat (4) @(negedge clk);
        check("R1 off-map write no transfer", {31'h0, spi_cs_n}, 32'h1);
        rd(8'h14, v);
        check("R1 off-map write no effect", v, 32'h0);
        rd(8'h10, v);
        check("R1 off-map read zero", v, 32'h0);

        // Directed corners
        do_read(14'h0000);
        do_read(14'h3fff);
        do_read(14'h2aaa);

        // R3 start while busy is ignored
        wr(8'h14, {16'h0, 14'h0123, 2'b01});
        repeat (30) @(negedge clk);
        wr(8'h14, {16'h0, 14'h3210, 2'b01});
        rd(8'h14, v);
        check("R3 busy start keeps address", {18'h0, v[15:2]}, 32'h0123);
        check("R3 busy flag held", {31'h0, v[0]}, 32'h1);
        wait_done(v);
        check("R3 original word returned", {16'h0, v[31:16]}, {16'h0, exp_word(14'h0123)});
        check("R3 original address on bus", {16'h0, shin[15:0]}, 32'h0246);

        // R3 write with start bit clear is ignored
        keep = v;
        wr(8'h14, {16'hbeef, 14'h1111, 2'b00});
        repeat (4) @(negedge clk);
        rd(8'h14, v);
        check("R3 no-start write ignored", v, keep);
        check("R3 no-start write no frame", {31'h0, spi_cs_n}, 32'h1);

        // Random reads
        for (int k = 0; k < 20; k++) do_read(14'($urandom));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule